// File: doc/BRIEF.md
# Configuration-Image Identifier Extractor

This block searches a byte-addressed configuration image for a 64-bit world-wide name and returns it. The image sits in a synchronous memory. The block reads that memory one byte at a time through an address and read-enable port, and each data byte arrives one cycle after its request. After a start pulse the block walks a chain of resource tags. Each tag is either a one-byte-header small tag or a three-byte-header large tag. The block jumps from tag to tag by the length each header announces.

Only one kind of large tag is of interest. Inside it, the block walks a list of sub-fields. When a sub-field carries the identifier name, the block shifts eight bytes into the result and records where the first of them was stored. When the scan ends, the block raises `done` for one cycle. At that point `found`, `wwn` and `wwn_offset` hold the result of the whole walk. An offset of zero means no identifier was seen. The block is typically run once after reset by the bring-up logic, which needs the adapter's factory name.

Top module: `wwn_extract`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `wwn` and `wwn_offset` are all zero.
- R2: A header byte with bit 7 at 0 is a small tag of total length 1 plus header bits 2:0. Its body bytes are never interpreted as headers.
- R3: A small tag whose header bits 6:3 are all ones (header 0x78 to 0x7F) ends the scan. Nothing after it is examined.
- R4: A header byte with bit 7 at 1 is a large tag named by bits 6:0. Its total length is 3 plus the 16-bit count in the next two bytes, low byte first. Large tags other than name 0x0D are skipped whole.
- R5: Only tags whose header sits at a byte offset below 128 are parsed. A tag at offset 128 or higher ends the scan.
- R6: Inside tag 0x0D, sub-fields start 3 bytes after the tag header. A sub-field is named by bits 5:0 of its first byte and has a 16-bit count, low byte first, in the next two bytes. The walk advances by count plus 3 while the sub-field offset is below the tag end.
- R7: Sub-field 0x3C carries the 8-byte identifier starting 3 bytes after the sub-field header. The first stored byte lands in `wwn[63:56]`. `wwn_offset` is the address of that first byte, and `found` is 1.
- R8: If the byte 3 after a 0x0D tag header is 0x3B, the tag counts as 6 bytes long and its sub-fields are not searched.
- R9: When no identifier is seen, `found` is 0, `wwn` is 0 and `wwn_offset` is 0 at `done`.
- R10: Every start accepted while idle gives exactly one single-cycle `done` pulse. A start while `busy` has no effect. Each byte used is the one returned for the address presented with `mem_rd` high in the previous cycle.
- R11: When several identifier sub-fields appear in the image, the last one walked determines `wwn` and `wwn_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan from offset 0 when idle |
| mem_rd | output | 1 | Read request to the image memory |
| mem_addr | output | ADDR_W | Byte address of the read request |
| mem_rdata | input | 8 | Byte returned one cycle after the request |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| found | output | 1 | An identifier was located during the last scan |
| wwn | output | 64 | Identifier, first stored byte in the top bits |
| wwn_offset | output | LEN_W+3 | Address of the first identifier byte, 0 when none |

## Verification
A wrong tag pointer misreads every header that follows it. That error shows up at `done` as a missing identifier, a wrong offset, or an identifier where none exists, so the images mix decoy bytes that would look like 0x0D tags or 0x3C sub-fields if parsed from the wrong position. A slip in the sub-field walk or the byte counter shows as a shifted or partly stale `wwn` value in the same scan. A fault in the state sequencing shows as a missing, doubled or hung `done`, which the bench catches within one scan.

// File: rtl/wwn_pkg.sv
package wwn_pkg;

    // Scan controller states
    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_CHK,
        S_HDR_RX,
        S_LEN_LO,
        S_LEN_HI,
        S_FIRST,
        S_SUB_CHK,
        S_SUB_HDR,
        S_SUB_LO,
        S_SUB_HI,
        S_WWN,
        S_FIN
    } scan_st_e;

    // Field values the walker keys on
    localparam logic [3:0] END_TAG_NAME = 4'hF;
    localparam logic [6:0] HOST_TAG     = 7'h0D;
    localparam logic [5:0] ID_SUBFIELD  = 6'h3C;
    localparam logic [7:0] SHORT_MARK   = 8'h3B;
    localparam int         SHORT_LEN    = 6;

endpackage

// File: rtl/wwn_hdr_decode.sv
module wwn_hdr_decode (
    input  logic [7:0] hdr,
    output logic       is_large,
    output logic       is_end,
    output logic [3:0] small_len,
    output logic       is_host
);
    import wwn_pkg::*;

    always_comb begin
        is_large  = hdr[7];
        is_end    = !hdr[7] && (hdr[6:3] == END_TAG_NAME);
        small_len = 4'd1 + {1'b0, hdr[2:0]};
        is_host   = hdr[7] && (hdr[6:0] == HOST_TAG);
    end

endmodule

// File: rtl/wwn_shift_reg.sv
module wwn_shift_reg #(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] q
);
    logic [8*BYTES-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)
            q_d = '0;
        else if (shift)
            q_d = {q_q[8*BYTES-9:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

endmodule

// File: rtl/wwn_extract.sv
module wwn_extract #(
    parameter int ADDR_W     = 9,
    parameter int LEN_W      = 16,
    parameter int SCAN_LIMIT = 128,
    parameter int WWN_BYTES  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   mem_rd,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [7:0]             mem_rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   found,
    output logic [8*WWN_BYTES-1:0] wwn,
    output logic [LEN_W+2:0]       wwn_offset
);
    import wwn_pkg::*;

    localparam int OFF_W = LEN_W + 3;
    localparam int CNT_W = (WWN_BYTES > 1) ? $clog2(WWN_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WWN_BYTES - 1);

    typedef struct packed {
        scan_st_e          st;
        logic [OFF_W-1:0]  tag_pos;
        logic [OFF_W-1:0]  tag_end;
        logic              tag_hit;
        logic [OFF_W-1:0]  sub_pos;
        logic [OFF_W-1:0]  sub_next;
        logic [5:0]        sub_name;
        logic [7:0]        len_lo;
        logic [CNT_W-1:0]  cnt;
        logic [OFF_W-1:0]  off;
        logic              found;
    } scan_t;

    scan_t s_d, s_q;

    logic             rd_en;
    logic [OFF_W-1:0] rd_addr;
    logic             sh_clr, sh_en;

    logic             h_large, h_end, h_host;
    logic [3:0]       h_small_len;

    logic [OFF_W-1:0] big_end, sub_end, sub_first, wwn_first;

    wwn_hdr_decode u_dec (
        .hdr       (mem_rdata),
        .is_large  (h_large),
        .is_end    (h_end),
        .small_len (h_small_len),
        .is_host   (h_host)
    );

    always_comb begin
        big_end   = s_q.tag_pos + OFF_W'(3) + OFF_W'({mem_rdata, s_q.len_lo});
        sub_end   = s_q.sub_pos + OFF_W'(3) + OFF_W'({mem_rdata, s_q.len_lo});
        sub_first = s_q.tag_pos + OFF_W'(3);
        wwn_first = s_q.sub_pos + OFF_W'(3);
    end

    always_comb begin
        s_d     = s_q;
        rd_en   = 1'b0;
        rd_addr = '0;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st      = S_HDR_CHK;
                    s_d.tag_pos = '0;
                    s_d.off     = '0;
                    s_d.found   = 1'b0;
                    sh_clr      = 1'b1;
                end
            end
            S_HDR_CHK: begin
                if (s_q.tag_pos < OFF_W'(SCAN_LIMIT)) begin
                    rd_en   = 1'b1;
                    rd_addr = s_q.tag_pos;
                    s_d.st  = S_HDR_RX;
                end else begin
                    s_d.st  = S_FIN;
                end
            end
            S_HDR_RX: begin
                if (!h_large) begin
                    s_d.tag_pos = s_q.tag_pos + OFF_W'(h_small_len);
                    s_d.st      = h_end ? S_FIN : S_HDR_CHK;
                end else begin
                    s_d.tag_hit = h_host;
                    rd_en       = 1'b1;
                    rd_addr     = s_q.tag_pos + OFF_W'(1);
                    s_d.st      = S_LEN_LO;
                end
            end
            S_LEN_LO: begin
                s_d.len_lo = mem_rdata;
                rd_en      = 1'b1;
                rd_addr    = s_q.tag_pos + OFF_W'(2);
                s_d.st     = S_LEN_HI;
            end
            S_LEN_HI: begin
                s_d.tag_end = big_end;
                if (s_q.tag_hit) begin
                    rd_en   = 1'b1;
                    rd_addr = sub_first;
                    s_d.st  = S_FIRST;
                end else begin
                    s_d.tag_pos = big_end;
                    s_d.st      = S_HDR_CHK;
                end
            end
            S_FIRST: begin
                if (mem_rdata == SHORT_MARK) begin
                    s_d.tag_pos = s_q.tag_pos + OFF_W'(SHORT_LEN);
                    s_d.st      = S_HDR_CHK;
                end else if (sub_first < s_q.tag_end) begin
                    s_d.sub_pos  = sub_first;
                    s_d.sub_name = mem_rdata[5:0];
                    rd_en        = 1'b1;
                    rd_addr      = sub_first + OFF_W'(1);
                    s_d.st       = S_SUB_LO;
                end else begin
                    s_d.tag_pos = s_q.tag_end;
                    s_d.st      = S_HDR_CHK;
                end
            end
            S_SUB_CHK: begin
                if (s_q.sub_pos < s_q.tag_end) begin
                    rd_en   = 1'b1;
                    rd_addr = s_q.sub_pos;
                    s_d.st  = S_SUB_HDR;
                end else begin
                    s_d.tag_pos = s_q.tag_end;
                    s_d.st      = S_HDR_CHK;
                end
            end
            S_SUB_HDR: begin
                s_d.sub_name = mem_rdata[5:0];
                rd_en        = 1'b1;
                rd_addr      = s_q.sub_pos + OFF_W'(1);
                s_d.st       = S_SUB_LO;
            end
            S_SUB_LO: begin
                s_d.len_lo = mem_rdata;
                rd_en      = 1'b1;
                rd_addr    = s_q.sub_pos + OFF_W'(2);
                s_d.st     = S_SUB_HI;
            end
            S_SUB_HI: begin
                s_d.sub_next = sub_end;
                if (s_q.sub_name == ID_SUBFIELD) begin
                    s_d.cnt = '0;
                    rd_en   = 1'b1;
                    rd_addr = wwn_first;
                    s_d.st  = S_WWN;
                end else begin
                    s_d.sub_pos = sub_end;
                    s_d.st      = S_SUB_CHK;
                end
            end
            S_WWN: begin
                sh_en = 1'b1;
                if (s_q.cnt == LAST_CNT) begin
                    s_d.found   = 1'b1;
                    s_d.off     = wwn_first;
                    s_d.sub_pos = s_q.sub_next;
                    s_d.st      = S_SUB_CHK;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                    rd_en   = 1'b1;
                    rd_addr = wwn_first + OFF_W'(s_q.cnt) + OFF_W'(1);
                    s_d.st  = S_WWN;
                end
            end
            S_FIN: begin
                s_d.st = S_IDLE;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    wwn_shift_reg #(.BYTES(WWN_BYTES)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sh_clr),
        .shift (sh_en),
        .din   (mem_rdata),
        .q     (wwn)
    );

    assign mem_rd     = rd_en;
    assign mem_addr   = rd_addr[ADDR_W-1:0];
    assign busy       = (s_q.st != S_IDLE);
    assign done       = (s_q.st == S_FIN);
    assign found      = s_q.found;
    assign wwn_offset = s_q.off;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held longer than one cycle"); // R10

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)) else $error("scan began without start"); // R10

    AST_DATA_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st inside {S_HDR_RX, S_LEN_LO, S_LEN_HI, S_FIRST, S_SUB_HDR,
                        S_SUB_LO, S_SUB_HI, S_WWN}) |-> $past(mem_rd))
        else $error("byte consumed without a read"); // R10

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (wwn_offset == '0 && wwn == '0))
        else $error("miss reported with nonzero result"); // R9

    AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (wwn_offset >= OFF_W'(6)))
        else $error("identifier offset below first legal position"); // R7

endmodule

// File: tb/wwn_extract_tb.sv
`timescale 1ns/1ps
module wwn_extract_tb;

    localparam int ADDR_W = 9;
    localparam int MEM_N  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done, found;
    logic [63:0] wwn;
    logic [18:0] wwn_offset;

    logic [7:0]  mem [0:MEM_N-1];

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    always #10 clk = ~clk;

    wwn_extract u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .found      (found),
        .wwn        (wwn),
        .wwn_offset (wwn_offset)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(longint a);
        return mem[int'(a & (MEM_N - 1))];
    endfunction

    // Expected result from the tag rules alone
    function automatic void ref_scan(output logic [63:0] w, output longint o);
        longint i, len, j, sl;
        logic [7:0] z, sn;
        bit fin;
        w = '0; o = 0; i = 0; fin = 0;
        while (i < 128 && !fin) begin
            z = rdb(i);
            if (!z[7]) begin
                len = 1 + z[2:0];
                if (z[6:3] == 4'hF) fin = 1;
            end else begin
                len = 3 + rdb(i + 1) + 256 * rdb(i + 2);
                if (z[6:0] == 7'h0D) begin
                    j = i + 3;
                    if (rdb(j) == 8'h3B) begin
                        len = 6;
                    end else begin
                        while (j < i + len) begin
                            sn = rdb(j);
                            sl = rdb(j + 1) + 256 * rdb(j + 2);
                            if (sn[5:0] == 6'h3C) begin
                                for (int k = 0; k < 8; k++)
                                    w = {w[55:0], rdb(j + 3 + k)};
                                o = j + 3;
                            end
                            j = j + sl + 3;
                        end
                    end
                end
            end
            i = i + len;
        end
    endfunction

    task automatic fill(input logic [7:0] v);
        for (int a = 0; a < MEM_N; a++) mem[a] = v;
    endtask

    task automatic put_id_tag(input int base, input logic [63:0] w);
        mem[base]     = 8'h8D;
        mem[base + 1] = 8'd11;
        mem[base + 2] = 8'd0;
        mem[base + 3] = 8'h3C;
        mem[base + 4] = 8'd8;
        mem[base + 5] = 8'd0;
        for (int k = 0; k < 8; k++) mem[base + 6 + k] = w[63 - 8*k -: 8];
    endtask

    task automatic gen_image();
        int pos, q, nsub, sl, len, kind;
        for (int a = 0; a < MEM_N; a++) mem[a] = 8'($urandom % 128);
        pos = 0;
        while (pos < 128) begin
            kind = $urandom % 8;
            if (kind <= 2 || (kind == 7 && ($urandom % 3) != 0)) begin
                mem[pos] = {1'b0, 4'($urandom % 15), 3'($urandom)};
                pos += 1 + int'(mem[pos][2:0]);
            end else if (kind == 7) begin
                mem[pos] = {1'b0, 4'hF, 3'($urandom)};
                pos += 1 + int'(mem[pos][2:0]);
            end else if (kind == 3) begin
                mem[pos] = 8'h80 | 8'($urandom % 128);
                if (mem[pos] == 8'h8D) mem[pos] = 8'h8E;
                len = $urandom % 10;
                mem[pos + 1] = 8'(len);
                mem[pos + 2] = 8'h00;
                pos += 3 + len;
            end else begin
                q = pos + 3;
                nsub = $urandom % 4;
                for (int s = 0; s < nsub; s++) begin
                    if ($urandom % 2) begin
                        mem[q] = {1'b0, 1'($urandom), 6'h3C};
                        sl = 8 + $urandom % 3;
                    end else begin
                        mem[q] = 8'($urandom % 128);
                        sl = $urandom % 6;
                    end
                    mem[q + 1] = 8'(sl);
                    mem[q + 2] = 8'h00;
                    q += 3 + sl;
                end
                if (nsub > 0 && ($urandom % 6) == 0) mem[pos + 3] = 8'h3B;
                mem[pos] = 8'h8D;
                mem[pos + 1] = 8'(q - pos - 3);
                mem[pos + 2] = 8'h00;
                pos = q;
            end
        end
    endtask

    task automatic run_case(input string req, input bit twice);
        logic [63:0] ew;
        longint eo;
        int cyc;
        ref_scan(ew, eo);
        @(negedge clk);
        done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (twice) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (done_cnt == 0 && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R10", "done pulses per start", 64'(done_cnt), 64'd1);
        check(wwn == ew, req, "wwn", wwn, ew);
        check(64'(wwn_offset) == 64'(eo), req, "offset", 64'(wwn_offset), 64'(eo));
        check(found == (eo != 0), req, "found", 64'(found), 64'(eo != 0));
        check(!busy, "R10", "idle after done", 64'(busy), 64'd0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        fill(8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done at reset", {62'd0, busy, done}, 64'd0);
        check(!found && wwn == 0 && wwn_offset == 0, "R1", "result at reset",
              wwn | 64'(wwn_offset) | 64'(found), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 / R2: image of single-byte small tags, nothing to find
        fill(8'h00);
        run_case("R9", 0);
        check(wwn_offset == 0 && wwn == 0, "R9", "miss result zero", wwn, 64'd0);

        // R7: identifier tag at offset 0, first byte in the top bits
        fill(8'h00);
        put_id_tag(0, 64'h1122334455667788);
        mem[14] = 8'h78;
        run_case("R7", 0);
        check(wwn == 64'h1122334455667788, "R7", "byte order", wwn, 64'h1122334455667788);
        check(wwn_offset == 19'd6, "R7", "first byte offset", 64'(wwn_offset), 64'd6);

        // R10: second start while busy ignored
        run_case("R10", 1);

        // R2: small tags of varied length, decoy in their bodies
        fill(8'h00);
        mem[0] = 8'h03; mem[1] = 8'h8D; mem[2] = 8'h20;
        mem[4] = 8'h2A; mem[5] = 8'h8D;
        mem[7] = 8'h00;
        put_id_tag(8, 64'hA1B2C3D4E5F60718);
        mem[22] = 8'h78;
        run_case("R2", 0);
        check(wwn_offset == 19'd14, "R2", "offset after small tags", 64'(wwn_offset), 64'd14);

        // R3: end tag first stops the scan
        fill(8'h00);
        mem[0] = 8'h78;
        put_id_tag(1, 64'hDEADBEEF01020304);
        run_case("R3", 0);
        check(!found, "R3", "nothing after end tag", 64'(found), 64'd0);

        // R4: other large tag with identical contents skipped
        fill(8'h00);
        put_id_tag(0, 64'hCAFEF00D12345678);
        mem[0] = 8'h85;
        mem[14] = 8'h78;
        run_case("R4", 0);
        check(!found, "R4", "non-host large tag skipped", 64'(found), 64'd0);

        // R8: short-form host tag, real tag follows at +6
        fill(8'h00);
        mem[0] = 8'h8D; mem[1] = 8'h20; mem[2] = 8'h00; mem[3] = 8'h3B;
        put_id_tag(6, 64'h0F1E2D3C4B5A6978);
        mem[20] = 8'h78;
        run_case("R8", 0);
        check(wwn_offset == 19'd12, "R8", "short tag length 6", 64'(wwn_offset), 64'd12);

        // R5: tag at offset 120 parsed, tag at 128 not
        fill(8'h00);
        for (int t = 0; t < 15; t++) mem[8*t] = 8'h07;
        put_id_tag(120, 64'h8877665544332211);
        run_case("R5", 0);
        check(wwn_offset == 19'd126, "R5", "tag below limit", 64'(wwn_offset), 64'd126);
        fill(8'h00);
        for (int t = 0; t < 16; t++) mem[8*t] = 8'h07;
        put_id_tag(128, 64'h8877665544332211);
        run_case("R5", 0);
        check(!found, "R5", "tag at limit ignored", 64'(found), 64'd0);

        // R11 / R6: two identifier sub-fields, last wins
        fill(8'h00);
        put_id_tag(0, 64'h1111111111111111);
        mem[1] = 8'd22;
        mem[14] = 8'h7C; mem[15] = 8'd8; mem[16] = 8'd0;
        for (int k = 0; k < 8; k++) mem[17 + k] = 8'(8'hF0 + k);
        mem[25] = 8'h78;
        run_case("R11", 0);
        check(wwn == 64'hF0F1F2F3F4F5F6F7, "R11", "last identifier", wwn, 64'hF0F1F2F3F4F5F6F7);
        check(wwn_offset == 19'd17, "R6", "second sub-field offset", 64'(wwn_offset), 64'd17);

        // R6: random images with mixed tags and sub-fields
        for (int n = 0; n < 150; n++) begin
            gen_image();
            run_case("R6", (n % 5) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule